// File: doc/BRIEF.md
# Protected High-Side Switch Fault Controller

This block is the digital supervisor beside a protected high-side load switch. It reads the raw comparator flags from the analog front end: current limit reached, relative over-temperature, absolute over-temperature, thermal hysteresis recovered, and open-load or short-to-battery. Each flag passes through its own deglitch filter, and the block then decides whether the power stage's gate is commanded on. It drives an active-low fault pin with its own output enable, and it picks the level that the sense pin's output stage produces.

A thermal trip turns the channel off. Recovery works in one of two ways. In auto-retry mode the channel comes back after a minimum off time once the die has cooled. In latched mode the channel stays off until software toggles the enable input or the latch-mode input. An overcurrent event leaves the channel on, because the analog loop holds the current at the limit; only the fault is reported. Open-load detection is active only while the channel is commanded off. A diagnostic-enable input puts all reporting into high impedance and leaves the protection unchanged.

Top module: `lsw_fault_ctrl`

## Requirements
- R1: A fault class is recognized only after its raw flag has been sampled high on N consecutive clock edges. N is ILIM_DG for current limit, TREL_DG for relative thermal, TABS_DG for absolute thermal and OPEN_DG for open-load. The registered outputs show the fault after the (N+1)-th edge counted from the first high sample.
- R2: If the raw flag is sampled low before the count completes, the count restarts from zero. A broken run of highs is never recognized.
- R3: A recognized overcurrent with no thermal fault keeps gate_on_o high while en_i is high. It drives flt_oe_o=1, flt_n_o=0 and sns_sel_o=2, where 2 is the fault-high level.
- R4: A recognized relative or absolute thermal fault forces gate_on_o low and reports flt_oe_o=1 and sns_sel_o=2. The order of precedence is absolute thermal, then relative thermal, then overcurrent, then open-load. A thermal fault present together with an overcurrent fault therefore still turns the gate off.
- R5: With latch_mode_i low, a thermal shutdown retries. The first edge on which hys_ok_i is high at least RETRY_CYCLES+1 edges after the shutdown edge moves the channel back to running, and gate_on_o rises one edge later. While hys_ok_i is low the channel stays off.
- R6: With latch_mode_i high at the moment of the trip, the channel stays off until a falling edge on en_i or any change of latch_mode_i. After the fault is cleared, the gate follows en_i again.
- R7: The open-load flag is evaluated only while en_i is low. When it is recognized, the block reports flt_oe_o=1 and sns_sel_o=2. The report clears on the second edge after the raw flag falls.
- R8: While diag_en_i is low, flt_oe_o and sns_oe_o are 0 one edge later. Protection still acts: a thermal trip still drops the gate.
- R9: With no fault, flt_oe_o is 0 and gate_on_o follows en_i one edge later. sns_sel_o is 1 (proportional current) with en_i high and 0 (zero) with en_i low. sns_oe_o equals diag_en_i.
- R10: While rst is high, all outputs are held at gate_on_o=0, flt_n_o=1, flt_oe_o=0, sns_sel_o=0 and sns_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable command |
| diag_en_i | input | 1 | Diagnostic reporting enable |
| latch_mode_i | input | 1 | 1 selects latched thermal recovery, 0 selects auto-retry |
| ilim_raw_i | input | 1 | Raw current-limit comparator |
| trel_raw_i | input | 1 | Raw relative over-temperature comparator |
| tabs_raw_i | input | 1 | Raw absolute over-temperature comparator |
| hys_ok_i | input | 1 | Die has cooled through the thermal hysteresis |
| open_raw_i | input | 1 | Raw open-load / short-to-battery comparator |
| gate_on_o | output | 1 | Gate drive command |
| flt_n_o | output | 1 | Active-low fault level |
| flt_oe_o | output | 1 | Output enable of the fault pin |
| sns_sel_o | output | 2 | Sense level: 0 zero, 1 proportional, 2 fault-high |
| sns_oe_o | output | 1 | Output enable of the sense pin |

## Verification
Each fault class is given raw pulses of every length from one cycle up to one cycle past its deglitch count, and a separate run of highs is interrupted by a single low cycle. Together these show whether the count is exact, inclusive, and restarted on a drop. Overcurrent and relative thermal are raised together to show that thermal precedence overrides the hold-on behaviour. The retry path is run with hysteresis both ready and delayed, so that the minimum off time can be told apart from the cooling condition. The latched path is released once by a latch-input toggle and once by an enable falling edge. Open-load is raised with the channel off and with it on. Every combination of enable and diagnostic enable is swept with no fault present.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    SNS_ZERO  = 2'd0,
    SNS_PROP  = 2'd1,
    SNS_FLTHI = 2'd2
  } sns_sel_e;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_OPEN = 3'd1,
    CAUSE_ILIM = 3'd2,
    CAUSE_TREL = 3'd3,
    CAUSE_TABS = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    TH_RUN     = 2'd0,
    TH_RETRY   = 2'd1,
    TH_LATCHED = 2'd2
  } th_state_e;

  localparam int NUM_FLAGS = 4;
  localparam int IDX_ILIM  = 0;
  localparam int IDX_TREL  = 1;
  localparam int IDX_TABS  = 2;
  localparam int IDX_OPEN  = 3;

endpackage

// File: rtl/lsw_deglitch.sv
module lsw_deglitch #(
  parameter int DG_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic det_o
);
  localparam int CW = $clog2(DG_CYCLES + 1);
  localparam logic [CW-1:0] DG_LIM = CW'(DG_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!raw_i) begin
      cnt <= '0;
    end else if (cnt != DG_LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign det_o = (cnt == DG_LIM);

  AST_DET_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
    det_o |-> $past(raw_i)); // R1

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !raw_i |=> !det_o); // R2

endmodule

// File: rtl/lsw_thermal.sv
module lsw_thermal #(
  parameter int RETRY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic hys_ok_i,
  input  logic latch_mode_i,
  input  logic en_i,
  output logic run_o
);
  import lsw_pkg::*;

  localparam int RW = $clog2(RETRY_CYCLES + 1);
  localparam logic [RW-1:0] RETRY_LIM = RW'(RETRY_CYCLES);

  th_state_e     state;
  logic [RW-1:0] wait_cnt;
  logic          en_q;
  logic          latch_q;
  logic          release_req;

  assign release_req = (en_q & ~en_i) | (latch_q ^ latch_mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TH_RUN;
      wait_cnt <= '0;
      en_q     <= 1'b0;
      latch_q  <= 1'b0;
    end else begin
      en_q    <= en_i;
      latch_q <= latch_mode_i;
      case (state)
        TH_RUN: begin
          wait_cnt <= '0;
          if (trip_i) begin
            state <= latch_mode_i ? TH_LATCHED : TH_RETRY;
          end
        end
        TH_RETRY: begin
          if (wait_cnt == RETRY_LIM) begin
            if (hys_ok_i && !trip_i) begin
              state <= TH_RUN;
            end
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        TH_LATCHED: begin
          if (release_req) begin
            state <= TH_RUN;
          end
        end
        default: state <= TH_RUN;
      endcase
    end
  end

  assign run_o = (state == TH_RUN);

  AST_RETRY_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == TH_RETRY && wait_cnt != RETRY_LIM) |=> (state != TH_RUN)); // R5

  AST_RETRY_COOL: assert property (@(posedge clk) disable iff (rst)
    (state == TH_RETRY && !hys_ok_i) |=> (state != TH_RUN)); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == TH_LATCHED && $stable(latch_mode_i) && !$fell(en_i))
      |=> (state == TH_LATCHED)); // R6

endmodule

// File: rtl/lsw_report.sv
module lsw_report (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             diag_en_i,
  input  logic             run_i,
  input  lsw_pkg::cause_e  cause_i,
  output logic             gate_o,
  output logic             flt_n_o,
  output logic             flt_oe_o,
  output logic [1:0]       sns_sel_o,
  output logic             sns_oe_o
);
  import lsw_pkg::*;

  logic     thermal_now;
  logic     fault_any;
  logic     gate_d;
  sns_sel_e sel_d;

  always_comb begin
    thermal_now = (cause_i == CAUSE_TABS) || (cause_i == CAUSE_TREL);
    fault_any   = !run_i || (cause_i != CAUSE_NONE);
    gate_d      = en_i && run_i && !thermal_now;
    if (fault_any) begin
      sel_d = SNS_FLTHI;
    end else if (en_i) begin
      sel_d = SNS_PROP;
    end else begin
      sel_d = SNS_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o    <= 1'b0;
      flt_n_o   <= 1'b1;
      flt_oe_o  <= 1'b0;
      sns_sel_o <= SNS_ZERO;
      sns_oe_o  <= 1'b0;
    end else begin
      gate_o    <= gate_d;
      flt_n_o   <= ~fault_any;
      flt_oe_o  <= diag_en_i & fault_any;
      sns_sel_o <= sel_d;
      sns_oe_o  <= diag_en_i;
    end
  end

  AST_OFF_NO_GATE: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !gate_o); // R4

  AST_ILIM_KEEPS_ON: assert property (@(posedge clk) disable iff (rst)
    (cause_i == CAUSE_ILIM && run_i && en_i) |=> gate_o); // R3

  AST_DIAG_MUTE: assert property (@(posedge clk) disable iff (rst)
    !diag_en_i |=> (!flt_oe_o && !sns_oe_o)); // R8

  AST_FLT_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    flt_oe_o |-> !flt_n_o); // R9

endmodule

// File: rtl/lsw_fault_ctrl.sv
module lsw_fault_ctrl #(
  parameter int ILIM_DG      = 3,
  parameter int TREL_DG      = 3,
  parameter int TABS_DG      = 20,
  parameter int OPEN_DG      = 700,
  parameter int RETRY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       diag_en_i,
  input  logic       latch_mode_i,
  input  logic       ilim_raw_i,
  input  logic       trel_raw_i,
  input  logic       tabs_raw_i,
  input  logic       hys_ok_i,
  input  logic       open_raw_i,
  output logic       gate_on_o,
  output logic       flt_n_o,
  output logic       flt_oe_o,
  output logic [1:0] sns_sel_o,
  output logic       sns_oe_o
);
  import lsw_pkg::*;

  function automatic int dg_of(input int idx);
    case (idx)
      IDX_ILIM: return ILIM_DG;
      IDX_TREL: return TREL_DG;
      IDX_TABS: return TABS_DG;
      default:  return OPEN_DG;
    endcase
  endfunction

  logic [NUM_FLAGS-1:0] raw_vec;
  logic [NUM_FLAGS-1:0] det_vec;
  cause_e               cause;
  logic                 trip;
  logic                 run;

  always_comb begin
    raw_vec           = '0;
    raw_vec[IDX_ILIM] = ilim_raw_i;
    raw_vec[IDX_TREL] = trel_raw_i;
    raw_vec[IDX_TABS] = tabs_raw_i;
    raw_vec[IDX_OPEN] = open_raw_i & ~en_i;
  end

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_dg
    lsw_deglitch #(.DG_CYCLES(dg_of(gi))) u_dg (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_vec[gi]),
      .det_o (det_vec[gi])
    );
  end

  always_comb begin
    if (det_vec[IDX_TABS]) begin
      cause = CAUSE_TABS;
    end else if (det_vec[IDX_TREL]) begin
      cause = CAUSE_TREL;
    end else if (det_vec[IDX_ILIM]) begin
      cause = CAUSE_ILIM;
    end else if (det_vec[IDX_OPEN]) begin
      cause = CAUSE_OPEN;
    end else begin
      cause = CAUSE_NONE;
    end
  end

  assign trip = (cause == CAUSE_TABS) || (cause == CAUSE_TREL);

  lsw_thermal #(.RETRY_CYCLES(RETRY_CYCLES)) u_thermal (
    .clk          (clk),
    .rst          (rst),
    .trip_i       (trip),
    .hys_ok_i     (hys_ok_i),
    .latch_mode_i (latch_mode_i),
    .en_i         (en_i),
    .run_o        (run)
  );

  lsw_report u_report (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .diag_en_i (diag_en_i),
    .run_i     (run),
    .cause_i   (cause),
    .gate_o    (gate_on_o),
    .flt_n_o   (flt_n_o),
    .flt_oe_o  (flt_oe_o),
    .sns_sel_o (sns_sel_o),
    .sns_oe_o  (sns_oe_o)
  );

  AST_OPEN_ONLY_OFF: assert property (@(posedge clk) disable iff (rst)
    en_i |=> !det_vec[IDX_OPEN]); // R7

  AST_THERMAL_WINS: assert property (@(posedge clk) disable iff (rst)
    (det_vec[IDX_TREL] || det_vec[IDX_TABS]) |=> !gate_on_o); // R4

endmodule

// File: tb/lsw_fault_ctrl_test.sv
module lsw_fault_ctrl_test;
  localparam int ILIM_DG = 3;
  localparam int TREL_DG = 4;
  localparam int TABS_DG = 6;
  localparam int OPEN_DG = 8;
  localparam int RETRY   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, diag = 0, latchm = 0, ilim = 0, trel = 0, tabs = 0, hys = 0, openr = 0;
  logic gate, flt_n, flt_oe, sns_oe;
  logic [1:0] sns_sel;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lsw_fault_ctrl #(
    .ILIM_DG(ILIM_DG), .TREL_DG(TREL_DG), .TABS_DG(TABS_DG),
    .OPEN_DG(OPEN_DG), .RETRY_CYCLES(RETRY)
  ) uut (
    .clk(clk), .rst(rst), .en_i(en), .diag_en_i(diag), .latch_mode_i(latchm),
    .ilim_raw_i(ilim), .trel_raw_i(trel), .tabs_raw_i(tabs), .hys_ok_i(hys),
    .open_raw_i(openr), .gate_on_o(gate), .flt_n_o(flt_n), .flt_oe_o(flt_oe),
    .sns_sel_o(sns_sel), .sns_oe_o(sns_oe)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_raw(input int cls, input logic v);
    case (cls)
      0: ilim = v;
      1: trel = v;
      2: tabs = v;
      default: openr = v;
    endcase
  endtask

  function automatic int dg_of(input int cls);
    case (cls)
      0: return ILIM_DG;
      1: return TREL_DG;
      2: return TABS_DG;
      default: return OPEN_DG;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    en = 0; diag = 0; latchm = 0; ilim = 0; trel = 0; tabs = 0; hys = 0; openr = 0;
    tick(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    rst = 1'b1;
    tick(1);
    // R10 reset state
    chk("R10 gate", gate, 0);
    chk("R10 flt_n", flt_n, 1);
    chk("R10 flt_oe", flt_oe, 0);
    chk("R10 sns_sel", sns_sel, 0);
    chk("R10 sns_oe", sns_oe, 0);
    rst = 1'b0;

    // R9 / R8 sweep of en x diag with no fault
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        en = e[0]; diag = d[0];
        tick(2);
        chk("R9 gate follows en", gate, e);
        chk("R9 no fault", flt_oe, 0);
        chk("R9 sns_sel", sns_sel, e);
        chk("R8 sns_oe", sns_oe, d);
      end
    end

    // R1 / R2 pulse length sweep per class
    for (int c = 0; c < 4; c++) begin
      for (int len = 1; len <= dg_of(c) + 1; len++) begin
        bit seen;
        do_reset();
        en = (c == 3) ? 1'b0 : 1'b1;
        diag = 1; hys = 1;
        tick(2);
        set_raw(c, 1'b1);
        tick(len);
        set_raw(c, 1'b0);
        seen = (flt_oe == 1'b1);
        for (int w = 0; w < dg_of(c) + 4; w++) begin
          tick(1);
          if (flt_oe) seen = 1;
        end
        chk($sformatf("R1 class %0d len %0d recognized", c, len), seen, (len >= dg_of(c)) ? 1 : 0);
      end
    end

    // R1 exact latency and R3 overcurrent behaviour
    do_reset();
    en = 1; diag = 1; hys = 1;
    tick(2);
    ilim = 1;
    tick(ILIM_DG);
    chk("R1 ilim not yet", flt_oe, 0);
    tick(1);
    chk("R1 ilim recognized", flt_oe, 1);
    chk("R3 flt_n low", flt_n, 0);
    chk("R3 sns fault-high", sns_sel, 2);
    chk("R3 gate stays on", gate, 1);
    tick(20);
    chk("R3 gate still on", gate, 1);
    ilim = 0;
    tick(2);
    chk("R3 fault cleared", flt_oe, 0);
    chk("R9 sns back to prop", sns_sel, 1);

    // R2 interrupted run
    ilim = 1; tick(ILIM_DG - 1);
    ilim = 0; tick(1);
    ilim = 1; tick(ILIM_DG - 1);
    ilim = 0;
    begin
      bit seen2 = 0;
      for (int w = 0; w < 6; w++) begin
        if (flt_oe) seen2 = 1;
        tick(1);
      end
      chk("R2 broken run ignored", seen2, 0);
    end

    // R4 precedence and R5 retry timing
    do_reset();
    en = 1; diag = 1; hys = 1;
    tick(2);
    ilim = 1; trel = 1;
    tick(ILIM_DG + 1);
    chk("R3 ilim first keeps gate", gate, 1);
    chk("R3 ilim fault shown", flt_oe, 1);
    tick(TREL_DG - ILIM_DG);
    chk("R4 thermal wins gate off", gate, 0);
    chk("R4 sns fault-high", sns_sel, 2);
    ilim = 0; trel = 0;
    tick(RETRY / 2);
    chk("R5 fault shown while off", flt_oe, 1);
    tick(RETRY + 1 - RETRY / 2);
    chk("R5 still off at limit", gate, 0);
    tick(1);
    chk("R5 back on after retry", gate, 1);

    // R5 waits for hysteresis
    do_reset();
    en = 1; diag = 1; hys = 0;
    tick(2);
    tabs = 1;
    tick(TABS_DG + 1);
    chk("R4 tabs gate off", gate, 0);
    tabs = 0;
    tick(RETRY + 5);
    chk("R5 off while hot", gate, 0);
    hys = 1;
    tick(1);
    chk("R5 one edge after cool", gate, 0);
    tick(1);
    chk("R5 on after cool", gate, 1);

    // R6 latched recovery
    do_reset();
    latchm = 1; en = 1; diag = 1; hys = 1;
    tick(2);
    trel = 1;
    tick(TREL_DG + 1);
    trel = 0;
    tick(RETRY + 5);
    chk("R6 latched stays off", gate, 0);
    chk("R6 latched fault shown", flt_oe, 1);
    latchm = 0;
    tick(1);
    chk("R6 toggle edge gate", gate, 0);
    tick(1);
    chk("R6 latch toggle clears", gate, 1);
    latchm = 1;
    tick(2);
    trel = 1;
    tick(TREL_DG + 1);
    trel = 0;
    tick(RETRY + 5);
    chk("R6 second latch off", gate, 0);
    en = 0;
    tick(2);
    chk("R6 en fall clears fault", flt_oe, 0);
    chk("R6 gate off while en low", gate, 0);
    chk("R9 sns zero", sns_sel, 0);
    en = 1;
    tick(1);
    chk("R6 gate follows en", gate, 1);

    // R7 open-load
    do_reset();
    en = 0; diag = 1;
    tick(2);
    openr = 1;
    tick(OPEN_DG);
    chk("R7 open not yet", flt_oe, 0);
    tick(1);
    chk("R7 open recognized", flt_oe, 1);
    chk("R7 sns fault-high", sns_sel, 2);
    chk("R7 gate off", gate, 0);
    openr = 0;
    tick(2);
    chk("R7 open clears", flt_oe, 0);
    en = 1; openr = 1;
    tick(OPEN_DG + 5);
    chk("R7 ignored while on", flt_oe, 0);
    chk("R7 sns prop while on", sns_sel, 1);
    openr = 0;

    // R8 diag off keeps protection
    do_reset();
    en = 1; diag = 0; hys = 0;
    tick(2);
    tabs = 1;
    tick(TABS_DG + 1);
    chk("R8 protection acts", gate, 0);
    chk("R8 flt hi-z", flt_oe, 0);
    chk("R8 sns hi-z", sns_oe, 0);
    tabs = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule